// File: doc/BRIEF.md
# Clock Domain Generator with Source Select and Integer Divider

This block produces one domain clock for a system-on-chip clock controller. Five free-running source clocks come in: a slow real-time clock, the main oscillator and three PLL outputs. A single 32-bit control word, written and read back over a single-cycle synchronous register port, picks the source and sets an integer divide ratio. The ratio is built from two counts: a high-phase length and a low-phase length. A pass-through setting sends the selected source straight to the output.

A source change or a divider change is never applied at once. Software writes the request, then polls a status flag until it drops. A source change uses a break-before-make enable chain. The old source is shut off on its falling edge before the new one is let through, and that happens only after two of the new source's own rising edges. A divider change waits for the end of the current output period, so the output never carries a short pulse. The count width is a parameter (`CNT_W`). The default of 4 gives ratios up to 32. A 3-bit build stops at 16.

Top module: `clkdom_gen`

## Requirements
- R1: After reset the control word reads 0x01000001: source code 1 (oscillator), pass-through bit 24 set, both counts 0, status bits 3 and 25 clear. The domain clock then follows the oscillator.
- R2: Bits [2:0] hold the source code: 0 real-time clock, 1 oscillator, 2/3/4 the first/second/third PLL. A write carrying code 5, 6 or 7 leaves the selection unchanged and starts no switch.
- R3: Bit 3 reads 1 from the cycle after an accepted source change until the new source drives the output, then reads 0. At no time are two sources enabled together, and the output shows no pulse shorter than half of the fastest source period.
- R4: While bit 3 reads 1, the source field of any write is ignored.
- R5: With bit 24 clear, the output is high for (wait+1) and low for (hold+1) cycles of the selected source. The wait count is in bits [19:16] and the hold count in bits [23:20].
- R6: With bit 24 set, the output equals the selected source, whatever the counts are.
- R7: The counts and bit 24 are captured only by a write with bit 25 set. A write with bit 25 clear leaves all three unchanged.
- R8: Bit 25 reads 1 from the cycle after an accepted update until the new counts and pass-through setting are in effect, then clears by itself. While it reads 1, the count and pass-through fields of writes are ignored.
- R9: New divider settings take effect only at the end of a complete output period. The first period after a load starts with its high phase.
- R10: Any ratio r from 2 to 32 can be set with wait = r/2 - 1 and hold = r - wait - 2. The output period is then r source cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register port clock |
| rstN | input | 1 | Asynchronous active-low reset for all domains |
| wrEn | input | 1 | Single-cycle write strobe |
| wrData | input | 32 | Control word to write |
| rdData | output | 32 | Control word read-back with status bits |
| srcClk | input | 5 | Source clocks: [0] real-time, [1] oscillator, [2..4] PLLs |
| domClk | output | 1 | Generated domain clock |

## Verification
The bench measures high and low widths of the domain clock in time. It therefore catches a divider that is off by one in either phase, swaps the wait and hold counts, or keeps dividing in pass-through mode. It issues a second request while a source switch or a divider update is still pending. A design that accepted that second request would end on the wrong source or ratio. The bench writes an out-of-range source code and a count change without the update bit. Both must leave the read-back untouched. A monitor keeps the narrowest output pulse over the whole run. An overlapped or badly timed enable, or a mid-period divider load, would show up there as a runt or zero-width pulse.

// File: rtl/clkdom_pkg.sv
package clkdom_pkg;
  localparam int NUM_SRC = 5;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] RESET_SEL = 3'd1;
  localparam int BUSY_BIT = 3;
  localparam int WAIT_LSB = 16;
  localparam int HOLD_LSB = 20;
  localparam int BYP_BIT = 24;
  localparam int UPD_BIT = 25;

  typedef struct packed {
    logic                updTgl;
    logic [NUM_SRC-1:0]  selHot;
  } domCmd_t;
endpackage

// File: rtl/clkdom_ctrl.sv
module clkdom_ctrl import clkdom_pkg::*; #(
  parameter int CNT_W = 4
) (
  input  logic               busClk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [NUM_SRC-1:0] enHotRaw,
  input  logic               ackTgl,
  output domCmd_t            cmd,
  output logic [CNT_W-1:0]   waitCnt,
  output logic [CNT_W-1:0]   holdCnt,
  output logic               bypass
);
  localparam logic [NUM_SRC-1:0] RESET_HOT = NUM_SRC'(1) << RESET_SEL;

  logic [SEL_W-1:0]   selQ;
  logic [CNT_W-1:0]   waitQ, holdQ;
  logic               bypassQ, updTglQ;
  logic [NUM_SRC-1:0] enS1, enS2, selHot;
  logic               ackS1, ackS2;
  logic               switchBusy, updPending, srcOk;
  logic               unusedWr;

  assign unusedWr   = ^wrData;
  assign selHot     = NUM_SRC'(1) << selQ;
  assign switchBusy = (enS2 != selHot);
  assign updPending = (updTglQ != ackS2);
  assign srcOk      = (wrData[SEL_W-1:0] < SEL_W'(NUM_SRC));

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      enS1  <= RESET_HOT;
      enS2  <= RESET_HOT;
      ackS1 <= 1'b0;
      ackS2 <= 1'b0;
    end else begin
      enS1  <= enHotRaw;
      enS2  <= enS1;
      ackS1 <= ackTgl;
      ackS2 <= ackS1;
    end
  end

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      selQ    <= RESET_SEL;
      waitQ   <= '0;
      holdQ   <= '0;
      bypassQ <= 1'b1;
      updTglQ <= 1'b0;
    end else if (wrEn) begin
      if (!switchBusy && srcOk) selQ <= wrData[SEL_W-1:0];
      if (wrData[UPD_BIT] && !updPending) begin
        waitQ   <= wrData[WAIT_LSB +: CNT_W];
        holdQ   <= wrData[HOLD_LSB +: CNT_W];
        bypassQ <= wrData[BYP_BIT];
        updTglQ <= ~updTglQ;
      end
    end
  end

  always_comb begin
    rdData                      = '0;
    rdData[SEL_W-1:0]           = selQ;
    rdData[BUSY_BIT]            = switchBusy;
    rdData[WAIT_LSB +: CNT_W]   = waitQ;
    rdData[HOLD_LSB +: CNT_W]   = holdQ;
    rdData[BYP_BIT]             = bypassQ;
    rdData[UPD_BIT]             = updPending;
  end

  assign cmd.updTgl = updTglQ;
  assign cmd.selHot = selHot;
  assign waitCnt    = waitQ;
  assign holdCnt    = holdQ;
  assign bypass     = bypassQ;

  // R2
  sel_valid_chk: assert property (@(posedge busClk) disable iff (!rstN)
    selQ < SEL_W'(NUM_SRC));
  // R4
  sel_hold_busy_chk: assert property (@(posedge busClk) disable iff (!rstN)
    switchBusy |=> $stable(selQ));
  // R8
  cfg_hold_pending_chk: assert property (@(posedge busClk) disable iff (!rstN)
    updPending |=> ($stable(waitQ) && $stable(holdQ) && $stable(bypassQ)));
endmodule

// File: rtl/clkdom_datapath.sv
module clkdom_datapath import clkdom_pkg::*; #(
  parameter int CNT_W = 4
) (
  input  logic [NUM_SRC-1:0] srcClk,
  input  logic               rstN,
  input  domCmd_t            cmd,
  input  logic [CNT_W-1:0]   waitCnt,
  input  logic [CNT_W-1:0]   holdCnt,
  input  logic               bypass,
  output logic [NUM_SRC-1:0] enHot,
  output logic               ackTgl,
  output logic               domClk
);
  logic [NUM_SRC-1:0] gated;
  logic               rawClk;

  // break-before-make enable chain, one per source
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic [NUM_SRC-1:0] OWN_BIT = NUM_SRC'(1) << i;
    localparam logic RST_EN = (i == int'(RESET_SEL));
    logic reqS1, reqS2, enNeg, othersOn;

    assign othersOn = |(enHot & ~OWN_BIT);

    always_ff @(posedge srcClk[i] or negedge rstN) begin
      if (!rstN) begin
        reqS1 <= RST_EN;
        reqS2 <= RST_EN;
      end else begin
        reqS1 <= cmd.selHot[i] & ~othersOn;
        reqS2 <= reqS1;
      end
    end

    always_ff @(negedge srcClk[i] or negedge rstN) begin
      if (!rstN) enNeg <= RST_EN;
      else       enNeg <= reqS2;
    end

    assign enHot[i] = enNeg;
    assign gated[i] = srcClk[i] & enNeg;
  end

  assign rawClk = |gated;

  // divider running on the selected source
  logic               updS1, updS2, seenQ;
  logic [CNT_W-1:0]   waitL, holdL, cnt;
  logic               bypL, phaseHi, periodEnd;

  assign periodEnd = !phaseHi && (cnt == holdL);

  always_ff @(posedge rawClk or negedge rstN) begin
    if (!rstN) begin
      updS1   <= 1'b0;
      updS2   <= 1'b0;
      seenQ   <= 1'b0;
      waitL   <= '0;
      holdL   <= '0;
      bypL    <= 1'b1;
      cnt     <= '0;
      phaseHi <= 1'b1;
    end else begin
      updS1 <= cmd.updTgl;
      updS2 <= updS1;
      if (phaseHi) begin
        if (cnt == waitL) begin
          phaseHi <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end else if (periodEnd) begin
        phaseHi <= 1'b1;
        cnt     <= '0;
        if (updS2 != seenQ) begin
          waitL <= waitCnt;
          holdL <= holdCnt;
          bypL  <= bypass;
          seenQ <= updS2;
        end
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign ackTgl = seenQ;
  assign domClk = bypL ? rawClk : phaseHi;

  // R3
  always_comb begin
    if (rstN) src_exclusive_chk: assert ($onehot0(enHot));
  end
  // R9
  load_at_end_chk: assert property (@(posedge rawClk) disable iff (!rstN)
    !periodEnd |=> ($stable(waitL) && $stable(holdL) && $stable(bypL) && $stable(seenQ)));
  // R5
  phase_bound_chk: assert property (@(posedge rawClk) disable iff (!rstN)
    phaseHi |-> (cnt <= waitL));
  // R5
  low_bound_chk: assert property (@(posedge rawClk) disable iff (!rstN)
    !phaseHi |-> (cnt <= holdL));
endmodule

// File: rtl/clkdom_gen.sv
module clkdom_gen import clkdom_pkg::*; #(
  parameter int CNT_W = 4
) (
  input  logic         busClk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [31:0]  wrData,
  output logic [31:0]  rdData,
  input  logic [4:0]   srcClk,
  output logic         domClk
);
  domCmd_t            cmd;
  logic [NUM_SRC-1:0] enHot;
  logic               ackTgl, bypass;
  logic [CNT_W-1:0]   waitCnt, holdCnt;

  clkdom_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .busClk(busClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .enHotRaw(enHot), .ackTgl(ackTgl), .cmd(cmd),
    .waitCnt(waitCnt), .holdCnt(holdCnt), .bypass(bypass)
  );

  clkdom_datapath #(.CNT_W(CNT_W)) i_dp (
    .srcClk(srcClk), .rstN(rstN), .cmd(cmd), .waitCnt(waitCnt),
    .holdCnt(holdCnt), .bypass(bypass), .enHot(enHot), .ackTgl(ackTgl),
    .domClk(domClk)
  );
endmodule

// File: tb/test_clkdom_gen.sv
`timescale 1ns/1ps
module test_clkdom_gen;
  logic        busClk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [4:0]  srcClk = '0;
  logic        domClk;

  int testCnt = 0;
  int failCnt = 0;
  bit running = 1'b0;

  clkdom_gen i_clkdom_gen (
    .busClk(busClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .srcClk(srcClk), .domClk(domClk)
  );

  always #2  busClk    = ~busClk;     // 250 MHz
  always #20 srcClk[0] = ~srcClk[0];  // real-time, 40 ns
  always #5  srcClk[1] = ~srcClk[1];  // oscillator, 10 ns
  always #3  srcClk[2] = ~srcClk[2];  // PLL 1, 6 ns
  always #4  srcClk[3] = ~srcClk[3];  // PLL 2, 8 ns
  always #7  srcClk[4] = ~srcClk[4];  // PLL 3, 14 ns

  // narrowest pulse monitor
  longint minHigh = 64'd1000000000;
  longint minLow  = 64'd1000000000;
  longint tRise = 0, tFall = 0;
  always @(posedge domClk) begin
    tRise = longint'($realtime * 1000.0);
    if (running && (tRise - tFall) < minLow) minLow = tRise - tFall;
  end
  always @(negedge domClk) begin
    tFall = longint'($realtime * 1000.0);
    if (running && (tFall - tRise) < minHigh) minHigh = tFall - tRise;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfgWord(input int sel, input int w, input int h,
                                          input bit byp, input bit upd);
    logic [31:0] v = '0;
    v[2:0]   = 3'(sel);
    v[19:16] = 4'(w);
    v[23:20] = 4'(h);
    v[24]    = byp;
    v[25]    = upd;
    return v;
  endfunction

  task automatic busWrite(input logic [31:0] d);
    @(negedge busClk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge busClk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 5000; k++) begin
      @(negedge busClk);
      if (!rdData[3] && !rdData[25]) break;
    end
  endtask

  task automatic measure(output longint hi, output longint lo);
    realtime t0, t1, t2;
    repeat (3) @(posedge domClk);
    t0 = $realtime;
    @(negedge domClk);
    t1 = $realtime;
    @(posedge domClk);
    t2 = $realtime;
    hi = longint'((t1 - t0) * 1000.0);
    lo = longint'((t2 - t1) * 1000.0);
  endtask

  task automatic expectWave(input string req, input longint eHi, input longint eLo);
    longint hi, lo;
    measure(hi, lo);
    check(hi == eHi, {req, " high width ps"}, hi, eHi);
    check(lo == eLo, {req, " low width ps"}, lo, eLo);
  endtask

  task automatic testReset();
    @(negedge busClk);
    check(rdData == 32'h0100_0001, "R1 reset read-back", rdData, 32'h0100_0001);
    expectWave("R1 oscillator pass-through", 5000, 5000);
  endtask

  task automatic testDivide();
    busWrite(cfgWord(1, 3, 3, 0, 1));
    check(rdData[25] == 1'b1, "R8 pending after update", rdData[25], 1);
    waitIdle();
    check(rdData == cfgWord(1, 3, 3, 0, 0), "R7 update captured", rdData, cfgWord(1, 3, 3, 0, 0));
    expectWave("R5 wait3 hold3", 40000, 40000);
    busWrite(cfgWord(1, 0, 5, 0, 1));
    waitIdle();
    expectWave("R5 wait0 hold5", 10000, 60000);
  endtask

  task automatic testRatios();
    int rs[3] = '{2, 7, 32};
    foreach (rs[j]) begin
      int w = rs[j] / 2 - 1;
      int h = rs[j] - w - 2;
      busWrite(cfgWord(1, w, h, 0, 1));
      waitIdle();
      expectWave("R10 ratio", longint'(w + 1) * 10000, longint'(h + 1) * 10000);
    end
  endtask

  task automatic testNoUpdBit();
    busWrite(cfgWord(1, 7, 2, 1, 0));
    @(negedge busClk);
    check(rdData == cfgWord(1, 15, 15, 0, 0), "R7 no update bit", rdData, cfgWord(1, 15, 15, 0, 0));
    expectWave("R7 divider unchanged", 160000, 160000);
  endtask

  task automatic testBypass();
    busWrite(cfgWord(1, 15, 15, 1, 1));
    waitIdle();
    expectWave("R6 pass-through", 5000, 5000);
  endtask

  task automatic testSwitch();
    busWrite(cfgWord(2, 15, 15, 1, 0));
    check(rdData[3] == 1'b1, "R3 switching flag set", rdData[3], 1);
    waitIdle();
    check(rdData[2:0] == 3'd2, "R2 source code 2", rdData[2:0], 2);
    check(rdData[3] == 1'b0, "R3 switching flag clear", rdData[3], 0);
    expectWave("R3 PLL1 drives output", 3000, 3000);
  endtask

  task automatic testInvalid();
    busWrite(cfgWord(6, 15, 15, 1, 0));
    @(negedge busClk);
    check(rdData[2:0] == 3'd2, "R2 invalid code ignored", rdData[2:0], 2);
    check(rdData[3] == 1'b0, "R2 no switch started", rdData[3], 0);
    expectWave("R2 output unchanged", 3000, 3000);
  endtask

  task automatic testBusyIgnore();
    busWrite(cfgWord(3, 15, 15, 1, 0));
    busWrite(cfgWord(4, 15, 15, 1, 0));
    waitIdle();
    check(rdData[2:0] == 3'd3, "R4 write during switch ignored", rdData[2:0], 3);
    expectWave("R4 PLL2 drives output", 4000, 4000);
  endtask

  task automatic testPendingIgnore();
    busWrite(cfgWord(3, 1, 1, 0, 1));
    busWrite(cfgWord(3, 5, 5, 0, 1));
    waitIdle();
    check(rdData == cfgWord(3, 1, 1, 0, 0), "R8 write during pending ignored", rdData, cfgWord(3, 1, 1, 0, 0));
    expectWave("R8 first update applied", 16000, 16000);
  endtask

  task automatic testOtherSources();
    busWrite(cfgWord(0, 1, 1, 0, 0));
    waitIdle();
    check(rdData[2:0] == 3'd0, "R2 source code 0", rdData[2:0], 0);
    expectWave("R2 real-time clock divided", 80000, 80000);
    busWrite(cfgWord(4, 1, 1, 0, 0));
    waitIdle();
    expectWave("R2 PLL3 divided", 28000, 28000);
  endtask

  task automatic testPulses();
    check(minHigh >= 3000, "R3 R9 narrowest high pulse", minHigh, 3000);
    check(minLow >= 3000, "R3 R9 narrowest low pulse", minLow, 3000);
  endtask

  initial begin
    #23;
    @(negedge busClk);
    rstN = 1'b1;
    repeat (4) @(negedge busClk);
    running = 1'b1;
    testReset();
    testDivide();
    testRatios();
    testNoUpdBit();
    testBypass();
    testSwitch();
    testInvalid();
    testBusyIgnore();
    testPendingIgnore();
    testOtherSources();
    testPulses();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge busClk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule